// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block serializes data words into framed bit streams. Software writes a word into a holding register through a small write port. When a selectable start event occurs, the word moves into a shift register. The block then sends an optional field of synchronization bits, followed by the payload bits. Every bit advances on a rising edge of the chosen bit clock pin. The block is fully synchronous to the system clock `clk`. Each bit clock pin is sampled, and a rising edge on it is detected as a one-cycle tick.

Because the holding register and the shift register are separate, a second word can be queued while a frame is still going out. A ready flag shows that the holding register is free. An empty flag shows that nothing is held and no frame is in progress. In master mode the frame-sync line is an output, and it carries a pulse at the start of each frame. In slave mode the block leaves that line alone and can use the incoming frame-sync edge as its start event.

The controller has three states:
- `ST_IDLE`: no frame is running.
- `ST_SYNC`: the synchronization field is being sent.
- `ST_DATA`: the payload is being sent.

It has five transitions:
- IDLE→SYNC: on the start event, when a word is held and the sync length is non-zero.
- IDLE→DATA: on the start event, when a word is held and the sync length is zero.
- SYNC→DATA: on the tick of the last sync bit.
- DATA→IDLE: on the tick of the last payload bit.
- All other cases: the state holds.

Top module: `sstx_frame_tx`

## Requirements
- R1: A held word moves into the shift register only on the start event selected by mode bits [1:0]. Code 0 (or 3) starts at once. Code 1 starts on a rising edge of `fs_in`. Code 2 starts on a falling edge of `fs_in`. Until that event, `tx_ready` stays 0.
- R2: Mode bits [11:7] set the sync length, from 0 to 16 bits. Values above 16 act as 16. The sync field is sent before the payload, taken from the low bits of the sync register (address 1), highest of those bits first.
- R3: Mode bits [6:2] hold the payload length minus one, so lengths run from 2 to 32 bits. A field value of 0 acts as 1.
- R4: Mode bit 12 selects bit order: 1 sends the LSB first, 0 sends the MSB first.
- R5: Mode bit 14 selects the bit clock: 0 selects `txc_pin` and 1 selects `rxc_pin`. `sd_out` moves to the next bit one `clk` cycle after a rising edge of the selected pin. Edges on the other pin have no effect.
- R6: `tx_ready` rises in the cycle the held word moves into the shift register. It falls when a holding write (address 2) is accepted.
- R7: `tx_empty` is 1 only when no word is held and the controller is idle.
- R8: Mode bit 13 selects master mode, which sets `fs_oe`. In master mode `fs_out` is 1 from the frame start until the first bit-clock tick; otherwise it stays 0.
- R9: A holding write while `tx_ready` is 0 is discarded and sets `tx_overrun`. `tx_overrun` stays set until the next mode write (address 0).
- R10: After reset, `tx_ready`=1, `tx_empty`=1, `tx_overrun`=0, `sd_out`=0, `fs_out`=0 and `fs_oe`=0. `sd_out` is 0 whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mode, 1 sync data, 2 holding data |
| wr_data | input | DW | Write data |
| txc_pin | input | 1 | Transmit bit clock pin |
| rxc_pin | input | 1 | Receive-side bit clock pin, usable as an alternative bit clock |
| fs_in | input | 1 | Incoming frame sync |
| sd_out | output | 1 | Serial data |
| fs_out | output | 1 | Frame-sync pulse (master mode) |
| fs_oe | output | 1 | Frame-sync output enable |
| tx_ready | output | 1 | Holding register free |
| tx_empty | output | 1 | Nothing held and nothing shifting |
| tx_overrun | output | 1 | Discarded holding write seen |

## Verification
The bench builds the block at its defaults: DW=32 and SYNC_W=16. This makes both the longest payload (32 bits) and the sync-length clamp at 16 reachable. At these defaults the mode fields sit at the bit positions listed in the requirements. The bench also covers these cases:
- a 2-bit frame, produced by a length field of 0;
- back-to-back frames that stream straight from the holding register;
- a rejected third word, sent while a second word is queued.

// File: rtl/sstx_pkg.sv
package sstx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_DATA = 2'd2
    } sstx_state_e;

    localparam logic [1:0] START_NOW  = 2'd0;
    localparam logic [1:0] START_RISE = 2'd1;
    localparam logic [1:0] START_FALL = 2'd2;
endpackage

// File: rtl/sstx_clk_pick.sv
module sstx_clk_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_rx,
    input  logic txc_pin,
    input  logic rxc_pin,
    output logic tick
);
    logic sel_clk;
    logic sel_q;

    assign sel_clk = sel_rx ? rxc_pin : txc_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_clk;
    end

    assign tick = sel_clk & ~sel_q;
endmodule

// File: rtl/sstx_start_det.sv
module sstx_start_det
    import sstx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       fs_in,
    output logic       start_ev
);
    logic fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fs_in;
    end

    always_comb begin
        unique case (mode)
            START_RISE: start_ev = fs_in & ~fs_q;
            START_FALL: start_ev = ~fs_in & fs_q;
            default:    start_ev = 1'b1;
        endcase
    end
endmodule

// File: rtl/sstx_hold.sv
module sstx_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hold,
    input  logic [DW-1:0] wr_data,
    input  logic          clr_ovr,
    input  logic          take,
    output logic          hold_valid,
    output logic [DW-1:0] hold_data,
    output logic          overrun
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
            overrun    <= 1'b0;
        end else begin
            if (take) begin
                hold_valid <= 1'b0;
            end else if (wr_hold && !hold_valid) begin
                hold_valid <= 1'b1;
                hold_data  <= wr_data;
            end
            if (wr_hold && hold_valid) overrun <= 1'b1;
            else if (clr_ovr)          overrun <= 1'b0;
        end
    end

    assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && hold_valid) |=> overrun);
    assert_discard_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && hold_valid && !take) |=> (hold_valid && $stable(hold_data)));
endmodule

// File: rtl/sstx_frame_tx.sv
module sstx_frame_tx
    import sstx_pkg::*;
#(
    parameter int DW     = 32,
    parameter int SYNC_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          txc_pin,
    input  logic          rxc_pin,
    input  logic          fs_in,
    output logic          sd_out,
    output logic          fs_out,
    output logic          fs_oe,
    output logic          tx_ready,
    output logic          tx_empty,
    output logic          tx_overrun
);
    localparam int DLW   = $clog2(DW);
    localparam int SLW   = $clog2(SYNC_W + 1);
    localparam int CNTW  = (DLW > SLW) ? DLW : SLW;
    localparam int P_DL  = 2;
    localparam int P_SL  = P_DL + DLW;
    localparam int P_LSB = P_SL + SLW;
    localparam int P_MST = P_LSB + 1;
    localparam int P_CS  = P_MST + 1;

    logic [1:0]        cfg_start;
    logic [DLW-1:0]    cfg_dlen;
    logic [SLW-1:0]    cfg_slen;
    logic              cfg_lsb, cfg_mst, cfg_cs;
    logic [SYNC_W-1:0] sync_reg;

    logic wr_mode, wr_sync, wr_hold;
    logic tick, start_ev, take, hold_valid;
    logic [DW-1:0] hold_data;

    sstx_state_e       state_q, state_d;
    logic [CNTW-1:0]   cnt_q;
    logic [DW-1:0]     shift_q;
    logic [SYNC_W-1:0] sync_sh;
    logic              fs_pulse;

    logic [DLW-1:0]  dlen_eff;
    logic [SLW-1:0]  slen_eff;
    logic [CNTW-1:0] data_last, sync_last;

    assign wr_mode = wr_en && (wr_addr == 2'd0);
    assign wr_sync = wr_en && (wr_addr == 2'd1);
    assign wr_hold = wr_en && (wr_addr == 2'd2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_start <= START_NOW;
            cfg_dlen  <= DLW'(7);
            cfg_slen  <= '0;
            cfg_lsb   <= 1'b0;
            cfg_mst   <= 1'b0;
            cfg_cs    <= 1'b0;
            sync_reg  <= '0;
        end else begin
            if (wr_mode) begin
                cfg_start <= wr_data[1:0];
                cfg_dlen  <= wr_data[P_DL +: DLW];
                cfg_slen  <= wr_data[P_SL +: SLW];
                cfg_lsb   <= wr_data[P_LSB];
                cfg_mst   <= wr_data[P_MST];
                cfg_cs    <= wr_data[P_CS];
            end
            if (wr_sync) sync_reg <= wr_data[SYNC_W-1:0];
        end
    end

    assign dlen_eff  = (cfg_dlen == '0) ? DLW'(1) : cfg_dlen;
    assign slen_eff  = (cfg_slen > SLW'(SYNC_W)) ? SLW'(SYNC_W) : cfg_slen;
    assign data_last = CNTW'(dlen_eff);
    assign sync_last = CNTW'(slen_eff) - CNTW'(1);

    sstx_clk_pick u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_rx  (cfg_cs),
        .txc_pin (txc_pin),
        .rxc_pin (rxc_pin),
        .tick    (tick)
    );

    sstx_start_det u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (cfg_start),
        .fs_in    (fs_in),
        .start_ev (start_ev)
    );

    sstx_hold #(.DW(DW)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hold    (wr_hold),
        .wr_data    (wr_data),
        .clr_ovr    (wr_mode),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .overrun    (tx_overrun)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (hold_valid && start_ev) begin
                take    = 1'b1;
                state_d = (slen_eff != '0) ? ST_SYNC : ST_DATA;
            end
            ST_SYNC: if (tick && cnt_q == sync_last) state_d = ST_DATA;
            ST_DATA: if (tick && cnt_q == data_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shift_q  <= '0;
            sync_sh  <= '0;
            fs_pulse <= 1'b0;
        end else begin
            if (state_d != state_q)               cnt_q <= '0;
            else if (tick && state_q != ST_IDLE)  cnt_q <= cnt_q + CNTW'(1);

            if (take)
                shift_q <= hold_data;
            else if (state_q == ST_DATA && tick)
                shift_q <= cfg_lsb ? (shift_q >> 1) : (shift_q << 1);

            if (take)
                sync_sh <= sync_reg << (SLW'(SYNC_W) - slen_eff);
            else if (state_q == ST_SYNC && tick)
                sync_sh <= sync_sh << 1;

            if (take)      fs_pulse <= cfg_mst;
            else if (tick) fs_pulse <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_SYNC: sd_out = sync_sh[SYNC_W-1];
            ST_DATA: sd_out = cfg_lsb ? shift_q[0] : shift_q[dlen_eff];
            default: sd_out = 1'b0;
        endcase
        fs_out   = fs_pulse;
        fs_oe    = cfg_mst;
        tx_ready = !hold_valid;
        tx_empty = !hold_valid && (state_q == ST_IDLE);
    end

    assert_wait_for_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_ev) |=> (state_q == ST_IDLE));
    assert_ready_after_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_ready);
    assert_empty_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> ($past(state_q) == ST_DATA));
    assert_fs_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> $past(state_q == ST_IDLE && cfg_mst));
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (cnt_q <= data_last));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sd_out);
endmodule

// File: tb/sstx_frame_tx_tb.sv
`timescale 1ns/1ps
module sstx_frame_tx_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic        txc = 1'b0, rxc = 1'b0, fs_in = 1'b0;
    logic        sd_out, fs_out, fs_oe, tx_ready, tx_empty, tx_overrun;

    int n_cmp = 0, n_bad = 0;

    typedef struct { logic b; string tag; } exp_t;
    exp_t q[$];
    event ev_smp;

    always #2.5 clk = ~clk;

    sstx_frame_tx #(.DW(32), .SYNC_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .txc_pin(txc), .rxc_pin(rxc), .fs_in(fs_in), .sd_out(sd_out), .fs_out(fs_out),
        .fs_oe(fs_oe), .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_overrun(tx_overrun)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] expv, input string tag);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Monitor: pops one expected bit per sample request
    always @(ev_smp) begin
        exp_t e;
        if (q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R3: actual bit %0b expected none (queue empty)", sd_out);
        end else begin
            e = q.pop_front();
            chk({31'd0, sd_out}, {31'd0, e.b}, e.tag);
        end
    end

    function automatic logic [31:0] mk_mode(int st, int dm1, int sl, bit lsb, bit mst, bit cs);
        logic [31:0] m;
        m = '0;
        m[1:0]  = 2'(st);
        m[6:2]  = 5'(dm1);
        m[11:7] = 5'(sl);
        m[12]   = lsb;
        m[13]   = mst;
        m[14]   = cs;
        return m;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] d, input int len, input bit lsb, input string tag);
        for (int i = 0; i < len; i++) begin
            exp_t e;
            e.b = lsb ? d[i] : d[len-1-i];
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic push_sync(input logic [15:0] v, input int len);
        for (int i = 0; i < len; i++) begin
            exp_t e;
            e.b = v[len-1-i];
            e.tag = "R2";
            q.push_back(e);
        end
    endtask

    task automatic pulses(input int n, input bit use_rx, input bit smp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (smp) ->ev_smp;
            if (use_rx) rxc = 1'b1; else txc = 1'b1;
            @(negedge clk);
            @(negedge clk);
            if (use_rx) rxc = 1'b0; else txc = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready, 1, "R10 ready");
        chk(tx_empty, 1, "R10 empty");
        chk(tx_overrun, 0, "R10 overrun");
        chk(sd_out, 0, "R10 sd");
        chk(fs_out, 0, "R10 fs_out");
        chk(fs_oe, 0, "R10 fs_oe");

        // Master, immediate, 8 bits MSB first
        wr(2'd0, mk_mode(0, 7, 0, 0, 1, 0));
        wr(2'd2, 32'hA5);
        push_word(32'hA5, 8, 0, "R3");
        @(negedge clk);
        chk(tx_ready, 1, "R6 ready after move");
        chk(tx_empty, 0, "R7 busy not empty");
        chk(fs_out, 1, "R8 fs pulse high");
        chk(fs_oe, 1, "R8 fs_oe master");
        pulses(1, 0, 1);
        chk(fs_out, 0, "R8 fs pulse ends");
        pulses(7, 0, 1);
        @(negedge clk);
        chk(tx_empty, 1, "R7 empty after frame");
        chk(sd_out, 0, "R10 idle sd");

        // Slave, 5-bit sync then 12-bit LSB first
        wr(2'd1, 32'h16);
        wr(2'd0, mk_mode(0, 11, 5, 1, 0, 0));
        wr(2'd2, 32'h5C3);
        push_sync(16'h16, 5);
        push_word(32'h5C3, 12, 1, "R4");
        @(negedge clk);
        chk(fs_oe, 0, "R8 slave fs_oe");
        chk(fs_out, 0, "R8 slave fs_out");
        pulses(17, 0, 1);

        // 32-bit MSB first
        wr(2'd0, mk_mode(0, 31, 0, 0, 0, 0));
        wr(2'd2, 32'hDEADBEEF);
        push_word(32'hDEADBEEF, 32, 0, "R3");
        pulses(32, 0, 1);

        // Length field 0 acts as 2 bits
        wr(2'd0, mk_mode(0, 0, 0, 0, 0, 0));
        wr(2'd2, 32'hFFFF_FFFE);
        push_word(32'h2, 2, 0, "R3");
        pulses(2, 0, 1);

        // Sync length 20 clamps to 16
        wr(2'd1, 32'hB38D);
        wr(2'd0, mk_mode(0, 7, 20, 0, 0, 0));
        wr(2'd2, 32'h3C);
        push_sync(16'hB38D, 16);
        push_word(32'h3C, 8, 0, "R2");
        pulses(24, 0, 1);
        @(negedge clk);
        chk(tx_empty, 1, "R2 empty after clamped frame");

        // Rising-edge start; a falling edge must not start
        wr(2'd0, mk_mode(1, 7, 0, 0, 0, 0));
        @(negedge clk); fs_in = 1'b1;
        repeat (3) @(negedge clk);
        wr(2'd2, 32'h96);
        repeat (4) @(negedge clk);
        chk(tx_ready, 0, "R1 waits for rising edge");
        fs_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_ready, 0, "R1 falling edge ignored");
        chk(tx_empty, 0, "R7 held word not empty");
        fs_in = 1'b1;
        @(negedge clk);
        chk(tx_ready, 1, "R1 started on rising edge");
        push_word(32'h96, 8, 0, "R1");
        pulses(8, 0, 1);

        // Falling-edge start
        wr(2'd0, mk_mode(2, 7, 0, 0, 0, 0));
        wr(2'd2, 32'h4B);
        repeat (3) @(negedge clk);
        chk(tx_ready, 0, "R1 waits for falling edge");
        fs_in = 1'b0;
        @(negedge clk);
        chk(tx_ready, 1, "R1 started on falling edge");
        push_word(32'h4B, 8, 0, "R1");
        pulses(8, 0, 1);

        // Clock select: rxc drives, txc ignored
        wr(2'd0, mk_mode(0, 7, 0, 0, 0, 1));
        wr(2'd2, 32'hC3);
        push_word(32'hC3, 8, 0, "R5");
        @(negedge clk);
        pulses(3, 0, 0);
        chk(sd_out, 1, "R5 unselected pin ignored");
        pulses(8, 1, 1);

        // Double buffering and overrun
        wr(2'd0, mk_mode(0, 7, 0, 0, 0, 0));
        wr(2'd2, 32'h81);
        push_word(32'h81, 8, 0, "R6");
        @(negedge clk);
        chk(tx_ready, 1, "R6 ready while shifting");
        wr(2'd2, 32'h7E);
        push_word(32'h7E, 8, 0, "R9");
        chk(tx_ready, 0, "R6 ready falls on accept");
        wr(2'd2, 32'hFF);
        chk(tx_overrun, 1, "R9 overrun set");
        chk(tx_ready, 0, "R9 ready still low");
        pulses(16, 0, 1);
        @(negedge clk);
        chk(tx_empty, 1, "R9 discarded word not sent");
        chk(q.size(), 0, "R9 all expected bits seen");
        wr(2'd0, mk_mode(0, 7, 0, 0, 0, 0));
        chk(tx_overrun, 0, "R9 overrun cleared by mode write");

        summary();
        $finish;
    end
endmodule